// File: doc/BRIEF.md
# Hardware Volume Button Counters

This block turns front-panel volume button activity into state that software can read. It keeps two 3-bit counters that move together. A volume-up press steps both counters up by one and a volume-down press steps both down by one. The counters stop at 7 and at 0 and never wrap. A mute press leaves both counters alone. Every press of any of the three buttons raises a level interrupt, which stays high until software acknowledges it.

Software sees the counters through a byte-wide register that answers at four alias addresses. A read of any alias returns the same packed byte. The upper counter sits in bits 7:5, the lower counter in bits 3:1, and bits 4 and 0 read as zero. A write of any value to any alias returns both counters to their midpoint of 4, so the byte then reads 0x88. Software typically reads the byte after an interrupt and compares it with 0x88 to tell an up press (0xAA), a down press (0x66) or a mute press (0x88) apart. It then writes the register to re-arm the counters and acknowledges the interrupt.

Top module: `hw_vol_counters`

## Requirements
- R1: After reset both counters hold 4, a read of alias 0 returns 0x88, and irqOut is low.
- R2: A btnUp pulse without btnDown raises both counters by one. From the reset state the byte reads 0xAA.
- R3: A btnDown pulse without btnUp lowers both counters by one. From the reset state the byte reads 0x66.
- R4: Both counters saturate. An up press at 7 leaves the byte at 0xEE and a down press at 0 leaves it at 0x00. Such a press still raises the interrupt.
- R5: A btnMute pulse leaves both counters unchanged and raises the interrupt.
- R6: irqOut rises on the clock edge that samples any button pulse and then holds high until an edge samples irqAck with no pulse present. A pulse and an acknowledge on the same edge leave irqOut high.
- R7: A write of any data to any address 0 to 3 sets both counters to 4. Reads at addresses 0 to 3 all return the same byte.
- R8: When a write to an alias and a button pulse share a clock edge, the counters end at 4. The interrupt is still raised.
- R9: Bits 4 and 0 of the read byte are always 0.
- R10: An address of 4 or above is outside the alias window. A write there changes nothing, and a read there returns 0x00.
- R11: btnUp and btnDown on the same edge leave the counters unchanged and raise the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| btnUp | input | 1 | Volume-up press, one-cycle pulse |
| btnDown | input | 1 | Volume-down press, one-cycle pulse |
| btnMute | input | 1 | Mute press, one-cycle pulse |
| regAddr | input | 3 | Register address; aliases at 0 to 3 |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data; the value is ignored |
| regRdData | output | 8 | Packed counter byte, or 0x00 outside the window |
| irqOut | output | 1 | Level interrupt |
| irqAck | input | 1 | Interrupt acknowledge |

## Verification
Counter updates and the interrupt both settle one clock edge after the button, write or acknowledge that causes them. regRdData follows the counters combinationally, so it also depends on the address presented in the same cycle. The bench drives every stimulus on a falling edge and lets one rising edge pass. It then compares the read byte and irqOut with its model on the next falling edge, using the address it is still driving. Random mixes of presses, writes, acknowledges and addresses run alongside directed cases for saturation, collisions and the out-of-window address.

// File: rtl/hvc_pkg.sv
package hvc_pkg;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic clrMid;   // return counters to midpoint
    logic incStep;  // step both counters up
    logic decStep;  // step both counters down
    logic rdSel;    // address lies inside the alias window
  } hvcStrobe_t;

endpackage

// File: rtl/hvc_sat_counter.sv
module hvc_sat_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clrMid,
  input  logic             incStep,
  input  logic             decStep,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MID = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic atTop;
  logic atBottom;

  assign atTop    = (cnt == CNT_MAX);
  assign atBottom = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= CNT_MID;
    end else if (clrMid) begin
      cnt <= CNT_MID;
    end else if (incStep && !atTop) begin
      cnt <= cnt + CNT_ONE;
    end else if (decStep && !atBottom) begin
      cnt <= cnt - CNT_ONE;
    end
  end

  AST_MID_AFTER_CLR: assert property (@(posedge clk) disable iff (!rstN)
    clrMid |=> (cnt == CNT_MID)); // R7
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (!clrMid && incStep && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_ONE)); // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (!clrMid && decStep && !incStep && cnt != '0) |=> (cnt == $past(cnt) - CNT_ONE)); // R3
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (!clrMid && incStep && cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R4
  AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rstN)
    (!clrMid && decStep && cnt == '0) |=> (cnt == '0)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!clrMid && !incStep && !decStep) |=> $stable(cnt)); // R5

endmodule

// File: rtl/hvc_datapath.sv
module hvc_datapath
  import hvc_pkg::*;
#(
  parameter int CNT_W   = 3,
  parameter int NUM_CNT = 2,
  parameter int DATA_W  = NUM_CNT * (CNT_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  hvcStrobe_t        strobe,
  output logic [DATA_W-1:0] rdData
);

  localparam int FIELD_W = CNT_W + 1;

  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal;
  logic [DATA_W-1:0]             packedByte;

  for (genvar g = 0; g < NUM_CNT; g++) begin : gCnt
    hvc_sat_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk     (clk),
      .rstN    (rstN),
      .clrMid  (strobe.clrMid),
      .incStep (strobe.incStep),
      .decStep (strobe.decStep),
      .cnt     (cntVal[g])
    );
    // each field: counter in the upper bits, a zero in the lowest bit
    assign packedByte[g*FIELD_W +: FIELD_W] = {cntVal[g], 1'b0};
  end

  assign rdData = strobe.rdSel ? packedByte : '0;

  for (genvar g = 1; g < NUM_CNT; g++) begin : gTrack
    AST_COUNTERS_TRACK: assert property (@(posedge clk) disable iff (!rstN)
      cntVal[g] == cntVal[0]); // R2
  end

endmodule

// File: rtl/hvc_ctrl.sv
module hvc_ctrl
  import hvc_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int NUM_ALIAS = 4,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              btnUp,
  input  logic              btnDown,
  input  logic              btnMute,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              irqAck,
  output hvcStrobe_t        strobe,
  output logic              irqOut
);

  localparam logic [ADDR_W-1:0] ALIAS_END = ADDR_W'(NUM_ALIAS);

  logic aliasHit;
  logic wrHit;
  logic anyPress;
  logic unusedWrData;

  // write data carries no meaning: any value re-arms the counters
  assign unusedWrData = ^regWrData;

  assign aliasHit = (regAddr < ALIAS_END);
  assign wrHit    = regWrEn && aliasHit;
  assign anyPress = btnUp || btnDown || btnMute;

  always_comb begin
    strobe         = '0;
    strobe.rdSel   = aliasHit;
    strobe.clrMid  = wrHit;
    strobe.incStep = !wrHit && btnUp && !btnDown;
    strobe.decStep = !wrHit && btnDown && !btnUp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
    end else if (anyPress) begin
      irqOut <= 1'b1;
    end else if (irqAck) begin
      irqOut <= 1'b0;
    end
  end

  AST_IRQ_ON_PRESS: assert property (@(posedge clk) disable iff (!rstN)
    anyPress |=> irqOut); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !irqAck) |=> irqOut); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !anyPress) |=> !irqOut); // R6
  AST_QUIET_STAYS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!irqOut && !anyPress) |=> !irqOut); // R5
  AST_STEP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.incStep && strobe.decStep)); // R11

endmodule

// File: rtl/hw_vol_counters.sv
module hw_vol_counters
  import hvc_pkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int NUM_CNT   = 2,
  parameter int ADDR_W    = 3,
  parameter int NUM_ALIAS = 4,
  parameter int DATA_W    = NUM_CNT * (CNT_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              btnUp,
  input  logic              btnDown,
  input  logic              btnMute,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut,
  input  logic              irqAck
);

  hvcStrobe_t strobe;

  hvc_ctrl #(
    .ADDR_W    (ADDR_W),
    .NUM_ALIAS (NUM_ALIAS),
    .DATA_W    (DATA_W)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .btnUp     (btnUp),
    .btnDown   (btnDown),
    .btnMute   (btnMute),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .irqAck    (irqAck),
    .strobe    (strobe),
    .irqOut    (irqOut)
  );

  hvc_datapath #(
    .CNT_W   (CNT_W),
    .NUM_CNT (NUM_CNT),
    .DATA_W  (DATA_W)
  ) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rdData (regRdData)
  );

endmodule

// File: tb/test_hw_vol_counters.sv
module test_hw_vol_counters;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       btnUp = 1'b0, btnDown = 1'b0, btnMute = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irqOut;
  logic       irqAck = 1'b0;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  int expCnt = 4;
  bit expIrq = 1'b0;

  always #2 clk = ~clk;

  hw_vol_counters i_hw_vol_counters (
    .clk(clk), .rstN(rstN), .btnUp(btnUp), .btnDown(btnDown), .btnMute(btnMute),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut), .irqAck(irqAck)
  );

  function automatic logic [7:0] packByte(int c, logic [2:0] a);
    logic [2:0] v = 3'(c);
    return (a < 3'd4) ? {v, 1'b0, v, 1'b0} : 8'h00;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // drive on falling edge, model at rising edge, inputs released after it
  task automatic step(bit up, bit dn, bit mu, bit wr, logic [2:0] a, logic [7:0] d, bit ack);
    @(negedge clk);
    btnUp = up; btnDown = dn; btnMute = mu; regWrEn = wr;
    regAddr = a; regWrData = d; irqAck = ack;
    @(posedge clk);
    if (wr && a < 3'd4) expCnt = 4;
    else if (up && !dn) expCnt = (expCnt < 7) ? expCnt + 1 : 7;
    else if (dn && !up) expCnt = (expCnt > 0) ? expCnt - 1 : 0;
    if (up || dn || mu) expIrq = 1'b1;
    else if (ack) expIrq = 1'b0;
    @(negedge clk);
    btnUp = 0; btnDown = 0; btnMute = 0; regWrEn = 0; irqAck = 0;
  endtask

  task automatic idle(logic [2:0] a);
    step(0, 0, 0, 0, a, 8'h00, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset byte", regRdData, 8'h88);
    check("R1 reset irq", {7'd0, irqOut}, 8'h00);

    step(1, 0, 0, 0, 3'd0, 8'h00, 0);
    check("R2 up from mid", regRdData, 8'hAA);
    check("R6 irq after press", {7'd0, irqOut}, 8'h01);
    idle(3'd0);
    check("R6 irq held", {7'd0, irqOut}, 8'h01);
    step(0, 0, 0, 0, 3'd0, 8'h00, 1);
    check("R6 ack clears", {7'd0, irqOut}, 8'h00);

    step(0, 0, 0, 1, 3'd2, 8'h13, 0);
    check("R7 write alias 2 resets", regRdData, 8'h88);
    step(0, 1, 0, 0, 3'd1, 8'h00, 0);
    check("R3 down from mid", regRdData, 8'h66);
    idle(3'd3);
    check("R7 alias 3 same byte", regRdData, 8'h66);
    check("R9 reserved bits zero", regRdData & 8'h11, 8'h00);

    step(0, 0, 1, 0, 3'd0, 8'h00, 1);
    check("R5 mute keeps counters", regRdData, 8'h66);
    check("R6 press beats ack", {7'd0, irqOut}, 8'h01);

    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 3'd0, 8'h00, 0);
    check("R4 saturate top", regRdData, 8'hEE);
    check("R4 irq at top", {7'd0, irqOut}, 8'h01);
    for (int i = 0; i < 9; i++) step(0, 1, 0, 0, 3'd0, 8'h00, 1);
    check("R4 saturate bottom", regRdData, 8'h00);

    step(1, 1, 0, 0, 3'd0, 8'h00, 0);
    check("R11 up and down cancel", regRdData, 8'h00);
    step(0, 0, 0, 0, 3'd0, 8'h00, 1);
    step(1, 1, 0, 0, 3'd0, 8'h00, 0);
    check("R11 irq raised", {7'd0, irqOut}, 8'h01);

    step(1, 0, 0, 1, 3'd1, 8'hFF, 1);
    check("R8 write wins over press", regRdData, 8'h88);
    check("R8 irq still raised", {7'd0, irqOut}, 8'h01);

    step(1, 0, 0, 0, 3'd0, 8'h00, 0);
    step(0, 0, 0, 1, 3'd5, 8'h00, 0);
    check("R10 out-of-window read", regRdData, 8'h00);
    idle(3'd0);
    check("R10 write outside ignored", regRdData, 8'hAA);

    for (int i = 0; i < 3000; i++) begin
      bit up = ($urandom % 100) < 30;
      bit dn = ($urandom % 100) < 30;
      bit mu = ($urandom % 100) < 10;
      bit wr = ($urandom % 100) < 6;
      bit ak = ($urandom % 100) < 30;
      logic [2:0] a = (($urandom % 8) == 0) ? 3'($urandom % 4 + 4) : 3'($urandom % 4);
      step(up, dn, mu, wr, a, 8'($urandom), ak);
      check("R2 R3 R4 R7 R10 random byte", regRdData, packByte(expCnt, a));
      check("R6 random irq", {7'd0, irqOut}, {7'd0, expIrq});
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule